// File: doc/BRIEF.md
# NAND ECC Session Sequencer

This block holds the control and status state that sits beside a multi-bit NAND flash error-correction engine. Software writes a control word carrying a session-start command and a lock bit, and sets a two-bit engine-type field and a message-size select. The sequencer then counts the data bytes moving between the host and the flash. While the session is unlocked it issues one accumulate-enable strobe per byte, up to the configured message size.

When the host writes to the flash (encoding), the block issues a one-cycle load strobe after the final message byte. The engine then latches its computed parity. When the host reads from the flash (decoding), software locks the session after the message and reads the stored parity bytes. The last of those bytes causes a search-start strobe. The block then times a fixed search latency and raises a done flag in its status word. It also captures the engine's error-found answer. Flash transfers may go on during the search without affecting it. The parity arithmetic and the error locator are outside this block; they are reached only through the strobes and the error-found input.

Top module: `nand_ecc_seq`

## Requirements
- R1: After reset, `status_o` is 0x00, `lock_o` is 0, and every engine strobe is low.
- R2: A control write with bit 5 set while the lock (control bit 7) is already 0 raises `eng_clr_o` in that same cycle. It clears the done and error flags and restarts the byte count. It latches the size select: `cfg_short` 0 gives 512 bytes and 1 gives 24 bytes.
- R3: A control write with bit 5 set while the lock is 1 has no effect. `eng_clr_o` stays low and `status_o` is unchanged.
- R4: In an active, unlocked session, each `byte_valid` cycle raises `eng_en_o` in the same cycle, until the configured number of bytes has been accepted.
- R5: Bytes that arrive while locked, or after the configured number of bytes, leave `eng_en_o` low and do not advance the count. Control bit 7 sets the lock in the cycle after the write.
- R6: A session started with `cfg_type` other than 2'b01 stays idle, and `eng_en_o` never rises.
- R7: When `xfer_wr` is 1 for the final message byte, `eng_load_o` is high for exactly the next cycle.
- R8: With the session locked and the message complete, the `PAR_BYTES`-th accepted `par_valid` raises `eng_start_o` for the next cycle only. Further parity strobes do not restart the search.
- R9: Status bit 6 (done) rises exactly `SEARCH_CYC` cycles after `eng_start_o`. Status bit 0 then holds `eng_err_i` as sampled at completion, and it reads 0 whenever bit 6 is 0.
- R10: Byte and parity strobes arriving during the search neither raise `eng_en_o` nor move the completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word: bit 5 start session, bit 7 lock |
| cfg_short | input | 1 | Message size select: 0 = 512 bytes, 1 = 24 bytes |
| cfg_type | input | 2 | Engine type; 2'b01 selects the multi-bit mode |
| byte_valid | input | 1 | One data byte transferred this cycle |
| xfer_wr | input | 1 | Transfer direction: 1 = write to flash (encode) |
| par_valid | input | 1 | One stored parity byte read this cycle |
| eng_err_i | input | 1 | Engine's error-found result |
| status_o | output | 8 | Status word: bit 6 done, bit 0 error present |
| lock_o | output | 1 | Current lock bit |
| eng_en_o | output | 1 | Accumulate this byte into parity |
| eng_clr_o | output | 1 | Clear engine state (session start) |
| eng_load_o | output | 1 | Latch computed parity (encode end) |
| eng_start_o | output | 1 | Begin error search |

## Verification
The two functions that overlap are the error search's completion count and the flash transfer path. Data bytes and extra parity strobes can arrive in the very cycle the search timer expires. The bench toggles `byte_valid` and `par_valid` on every cycle from the start strobe through completion. It expects `eng_en_o` and `eng_start_o` to stay low throughout, and the done bit to appear in exactly the predicted cycle, no earlier and no later. A second overlap is a session-start write that arrives while the lock is set. It is judged by `eng_clr_o` staying low and the previous decode result persisting in the status word.

// File: rtl/nes_pkg.sv
package nes_pkg;
    localparam int CTRL_INIT_BIT = 5;
    localparam int CTRL_LOCK_BIT = 7;
    localparam int STAT_DONE_BIT = 6;
    localparam int STAT_ERR_BIT  = 0;
    localparam logic [1:0] TYPE_MULTI = 2'b01;

    typedef struct packed {
        logic active;
        logic short_sel;
        logic lock;
        logic done;
        logic err;
        logic searching;
        logic load;
        logic start;
    } seq_state_t;
endpackage

// File: rtl/nes_counter.sv
module nes_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/nes_search_timer.sv
module nes_search_timer #(
    parameter int LAT = 372
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expire
);
    localparam int TW = $clog2(LAT + 1);

    logic [TW-1:0] tick_q;

    nes_counter #(.W(TW)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (run && !expire),
        .cnt   (tick_q)
    );

    assign expire = run && !clr && (tick_q == TW'(LAT - 1));
endmodule

// File: rtl/nand_ecc_seq.sv
module nand_ecc_seq
    import nes_pkg::*;
#(
    parameter int LONG_LEN   = 512,
    parameter int SHORT_LEN  = 24,
    parameter int PAR_BYTES  = 13,
    parameter int SEARCH_CYC = 372
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic [7:0] ctrl_wdata,
    input  logic       cfg_short,
    input  logic [1:0] cfg_type,
    input  logic       byte_valid,
    input  logic       xfer_wr,
    input  logic       par_valid,
    input  logic       eng_err_i,
    output logic [7:0] status_o,
    output logic       lock_o,
    output logic       eng_en_o,
    output logic       eng_clr_o,
    output logic       eng_load_o,
    output logic       eng_start_o
);
    localparam int BW = $clog2(LONG_LEN + 1);
    localparam int PW = $clog2(PAR_BYTES + 1);

    seq_state_t st_d, st_q;
    logic [BW-1:0] byte_cnt, msg_len;
    logic [PW-1:0] par_cnt;
    logic init_ok, msg_full, byte_ok, last_byte;
    logic par_ok, par_last, search_expire;

    always_comb begin
        init_ok   = ctrl_we && ctrl_wdata[CTRL_INIT_BIT] && !st_q.lock;
        msg_len   = st_q.short_sel ? BW'(SHORT_LEN) : BW'(LONG_LEN);
        msg_full  = (byte_cnt == msg_len);
        byte_ok   = byte_valid && st_q.active && !st_q.lock && !msg_full && !init_ok;
        last_byte = byte_ok && (byte_cnt == msg_len - BW'(1));
        par_ok    = par_valid && st_q.active && st_q.lock && msg_full
                    && !st_q.searching && !st_q.done && !init_ok
                    && (par_cnt != PW'(PAR_BYTES));
        par_last  = par_ok && (par_cnt == PW'(PAR_BYTES - 1));

        st_d       = st_q;
        st_d.load  = last_byte && xfer_wr;
        st_d.start = par_last;
        if (ctrl_we)
            st_d.lock = ctrl_wdata[CTRL_LOCK_BIT];
        if (par_last)
            st_d.searching = 1'b1;
        if (search_expire) begin
            st_d.searching = 1'b0;
            st_d.done      = 1'b1;
            st_d.err       = eng_err_i;
        end
        if (init_ok) begin
            st_d.active    = (cfg_type == TYPE_MULTI);
            st_d.short_sel = cfg_short;
            st_d.done      = 1'b0;
            st_d.err       = 1'b0;
            st_d.searching = 1'b0;
            st_d.load      = 1'b0;
            st_d.start     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    nes_counter #(.W(BW)) u_bytes (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (init_ok),
        .inc   (byte_ok),
        .cnt   (byte_cnt)
    );

    nes_counter #(.W(PW)) u_parity (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (init_ok),
        .inc   (par_ok),
        .cnt   (par_cnt)
    );

    nes_search_timer #(.LAT(SEARCH_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (init_ok || par_last),
        .run    (st_q.searching),
        .expire (search_expire)
    );

    always_comb begin
        status_o                = '0;
        status_o[STAT_DONE_BIT] = st_q.done;
        status_o[STAT_ERR_BIT]  = st_q.done && st_q.err;
    end

    assign lock_o      = st_q.lock;
    assign eng_en_o    = byte_ok;
    assign eng_clr_o   = init_ok;
    assign eng_load_o  = st_q.load;
    assign eng_start_o = st_q.start;
endmodule

// File: rtl/nand_ecc_seq_chk.sv
module nand_ecc_seq_chk #(
    parameter int SEARCH_CYC = 372
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_we,
    input logic [7:0] ctrl_wdata,
    input logic [7:0] status_o,
    input logic       lock_o,
    input logic       eng_en_o,
    input logic       eng_clr_o,
    input logic       eng_load_o,
    input logic       eng_start_o
);
    localparam int GW = $clog2(SEARCH_CYC + 2) + 1;

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gap_q <= '0;
        else if (eng_start_o)
            gap_q <= GW'(1);
        else if (gap_q != '0 && !status_o[6] && gap_q != '1)
            gap_q <= gap_q + GW'(1);
    end

    // R3
    init_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ctrl_wdata[5] && lock_o) |-> !eng_clr_o);

    // R5
    no_feed_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_en_o |-> !lock_o);

    // R7
    load_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_load_o |-> $past(eng_en_o));

    // R8
    start_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start_o |-> lock_o && !eng_en_o);

    // R9
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[6]) |-> (gap_q == GW'(SEARCH_CYC)));

    // R9
    err_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] |-> status_o[6]);
endmodule

bind nand_ecc_seq nand_ecc_seq_chk #(.SEARCH_CYC(SEARCH_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_we     (ctrl_we),
    .ctrl_wdata  (ctrl_wdata),
    .status_o    (status_o),
    .lock_o      (lock_o),
    .eng_en_o    (eng_en_o),
    .eng_clr_o   (eng_clr_o),
    .eng_load_o  (eng_load_o),
    .eng_start_o (eng_start_o)
);

// File: tb/test_nand_ecc_seq.sv
`timescale 1ns/1ps
module test_nand_ecc_seq;
    localparam int S   = 372;
    localparam int PB  = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic       cfg_short = 1'b0;
    logic [1:0] cfg_type = 2'b00;
    logic       byte_valid = 1'b0;
    logic       xfer_wr = 1'b0;
    logic       par_valid = 1'b0;
    logic       eng_err_i = 1'b0;
    logic [7:0] status_o;
    logic       lock_o, eng_en_o, eng_clr_o, eng_load_o, eng_start_o;

    nand_ecc_seq #(.SEARCH_CYC(S), .PAR_BYTES(PB)) i_nand_ecc_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .cfg_short(cfg_short), .cfg_type(cfg_type), .byte_valid(byte_valid),
        .xfer_wr(xfer_wr), .par_valid(par_valid), .eng_err_i(eng_err_i),
        .status_o(status_o), .lock_o(lock_o), .eng_en_o(eng_en_o),
        .eng_clr_o(eng_clr_o), .eng_load_o(eng_load_o), .eng_start_o(eng_start_o)
    );

    always #10 clk = ~clk;

    typedef struct {
        int    cyc;
        int    sel;
        int    exp;
        string req;
    } item_t;

    item_t sbq[$];
    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int obs(int sel);
        case (sel)
            0: return int'(status_o);
            1: return int'(eng_en_o);
            2: return int'(eng_clr_o);
            3: return int'(eng_load_o);
            4: return int'(eng_start_o);
            default: return int'(lock_o);
        endcase
    endfunction

    function automatic void push(int off, int sel, int exp, string req);
        item_t it;
        it.cyc = cyc + off;
        it.sel = sel;
        it.exp = exp;
        it.req = req;
        sbq.push_back(it);
    endfunction

    // monitor: compare expected items due in this cycle
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].cyc == cyc) begin
                n_run++;
                if (obs(sbq[i].sel) != sbq[i].exp) begin
                    n_fail++;
                    $display("FAIL %s cycle %0d sel %0d: got %0h expected %0h",
                             sbq[i].req, cyc, sbq[i].sel, obs(sbq[i].sel), sbq[i].exp);
                end
                sbq.delete(i);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic ctrl_write(logic [7:0] v);
        ctrl_we = 1'b1;
        ctrl_wdata = v;
        tick();
        ctrl_we = 1'b0;
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            if (sbq.size() != 0) begin
                n_fail += sbq.size();
                $display("FAIL R1 pending checks: got %0d expected 0", sbq.size());
            end
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic run_search(int err, int status_exp);
        // parity bytes after lock and full message
        eng_err_i = err[0];
        for (int i = 0; i < PB; i++) begin
            par_valid = 1'b1;
            push(0, 4, 0, "R8");
            tick();
        end
        par_valid = 1'b0;
        push(0, 4, 1, "R8");
        push(S - 1, 0, 8'h00, "R9");
        push(S, 0, status_exp, "R9");
        for (int k = 0; k <= S + 1; k++) begin
            byte_valid = k[0];
            par_valid  = k[1];
            push(0, 1, 0, "R10");
            if (k > 0) push(0, 4, 0, "R10");
            tick();
        end
        byte_valid = 1'b0;
        par_valid  = 1'b0;
        eng_err_i  = 1'b0;
        push(0, 0, status_exp, "R9");
        tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        push(0, 0, 0, "R1");
        push(0, 5, 0, "R1");
        push(0, 1, 0, "R1");
        push(0, 4, 0, "R1");
        tick();

        // encode, 24-byte message
        cfg_type = 2'b01;
        cfg_short = 1'b1;
        push(0, 2, 1, "R2");
        ctrl_write(8'h20);
        push(0, 0, 0, "R2");
        xfer_wr = 1'b1;
        for (int i = 0; i < 24; i++) begin
            byte_valid = 1'b1;
            push(0, 1, 1, "R4");
            push(0, 3, 0, "R7");
            tick();
        end
        push(0, 3, 1, "R7");
        push(0, 1, 0, "R5");
        tick();
        byte_valid = 1'b0;
        push(0, 3, 0, "R7");
        tick();

        // decode, 512-byte message with error
        xfer_wr = 1'b0;
        cfg_short = 1'b0;
        push(0, 2, 1, "R2");
        ctrl_write(8'h20);
        for (int i = 0; i < 512; i++) begin
            byte_valid = 1'b1;
            push(0, 1, 1, (i == 511) ? "R2" : "R4");
            tick();
        end
        push(0, 1, 0, "R2");
        tick();
        byte_valid = 1'b0;
        ctrl_write(8'h80);
        push(0, 5, 1, "R5");
        byte_valid = 1'b1;
        push(0, 1, 0, "R5");
        tick();
        byte_valid = 1'b0;
        run_search(1, 8'h41);

        // init while locked ignored
        push(0, 2, 0, "R3");
        ctrl_write(8'hA0);
        push(0, 0, 8'h41, "R3");
        push(0, 5, 1, "R3");
        tick();
        ctrl_write(8'h00);
        push(0, 0, 8'h41, "R3");
        cfg_short = 1'b1;
        push(0, 2, 1, "R2");
        ctrl_write(8'h20);
        push(0, 0, 8'h00, "R2");

        // decode, 24-byte message, no error
        for (int i = 0; i < 24; i++) begin
            byte_valid = 1'b1;
            push(0, 1, 1, "R4");
            tick();
        end
        push(0, 1, 0, "R5");
        tick();
        byte_valid = 1'b0;
        ctrl_write(8'h80);
        run_search(0, 8'h40);

        // non-multi engine type stays idle
        ctrl_write(8'h00);
        cfg_type = 2'b10;
        ctrl_write(8'h20);
        push(0, 0, 8'h00, "R6");
        for (int i = 0; i < 5; i++) begin
            byte_valid = 1'b1;
            push(0, 1, 0, "R6");
            tick();
        end
        byte_valid = 1'b0;
        repeat (3) tick();
        wrap_up();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog expired: got timeout expected completion");
        wrap_up();
    end
endmodule